// File: doc/BRIEF.md
# Round-Robin Serial ADC Scanner

This block is a receive-only serial master that reads a set of external serial converters continuously, with no processor involvement. All converters share one serial data input. The block visits the channels one after another in a fixed round-robin order. For each visit it presents a channel-select code, runs one conversion frame of sixteen serial clocks, and moves the captured sample into a result register kept for that channel. A host reads the results through a simple one-cycle-latency read port. Each result carries a sticky flag that shows whether the value is new.

A format input picks one of three converter styles. Format 0 serves a single quad converter: 12-bit samples, at most four channels, and a 2-bit channel code wired straight to that device. Format 1 serves up to eight single-channel converters with 15-bit samples. Format 2 does the same with 16-bit samples. Formats 1 and 2 present a 3-bit code meant for an external 3-to-8 chip-select decoder. Format 3 behaves as format 2. The serial clock is derived from the system clock by a programmable half-period count. An enable input starts and stops scanning cleanly.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, `sclk` is 1, `frame_act` is 0, `csel` is 0 and `rd_valid` is 0. Every result register reads data 0 with new flag 0.
- R2: Each half period of `sclk` lasts `half_div` system clocks (nonzero). `sclk` is 1 whenever `frame_act` is 0. A frame's first falling edge of `sclk` comes exactly one half period after `frame_act` rises. Every frame contains exactly 16 rising edges of `sclk`, and `frame_act` falls together with the 16th.
- R3: `miso` is sampled on each rising edge of `sclk`, MSB first. The stored result is the last W captured bits, right-aligned with zeros above them. W is 12 for format 0, 15 for format 1, and 16 for formats 2 and 3.
- R4: Frames visit channels 0, 1, 2, … up to the last channel and then wrap to 0. The last channel is `ch_last` in formats 1 to 3, and the lesser of `ch_last` and 3 in format 0.
- R5: While `frame_act` is 1, `csel` holds the channel number of the current frame and stays constant. In format 0, bit 2 of `csel` is 0. While `frame_act` is 0, `csel` is 0.
- R6: Consecutive frames are separated by at least two serial clock periods (4 × `half_div` system clocks) with `frame_act` low.
- R7: At the end of each frame, the result is written into the register of the channel that was sampled, and that register's new flag is set.
- R8: A read request (`rd_en`=1 with `rd_addr`) returns, in the next cycle, `rd_valid`=1, the register contents on `rd_data`, and the new flag as it stood before the read on `rd_new`. The read clears the flag, so an immediate second read of the same channel returns `rd_new`=0.
- R9: When `scan_en` is cleared during a frame, that frame completes and is stored. After that, no further frame starts: `frame_act` stays 0, `sclk` stays 1 and `csel` stays 0. Setting `scan_en` again from idle restarts the scan at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Scanning enable |
| fmt_sel | input | 2 | Converter format: 0 quad 12-bit, 1 15-bit, 2/3 16-bit |
| ch_last | input | 3 | Highest channel number to visit |
| half_div | input | DIV_W | Serial clock half period in system clocks (zero acts as one) |
| sclk | output | 1 | Serial clock, idles high |
| csel | output | 3 | Channel select code |
| frame_act | output | 1 | High for the duration of each conversion frame |
| miso | input | 1 | Shared serial data input from all converters |
| rd_en | input | 1 | Read request |
| rd_addr | input | 3 | Channel number to read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 16 | Result register contents |
| rd_new | output | 1 | New flag of the register before this read |

## Verification
The hardest situation to reach is a disable that arrives in the middle of a frame. A correct design must still finish that frame, store it, and then stay parked, and it must restart at channel 0 on the next enable. Each scan scenario waits until a chosen number of frames have finished and the next frame has begun, then drops `scan_en` a few cycles into it. The bench checks that this last frame still has 16 clocks and lands in its register. It then watches the parked outputs over a long idle window, and the next scenario's first frame must select channel 0. A converter model in the bench drives a per-frame distinct word, MSB first, off the select code. This lets wrong channel routing or wrong alignment show up in the read-back results.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int CH_W       = 3;
    localparam int NUM_CH     = 1 << CH_W;
    localparam int SAMPLE_W   = 16;
    localparam int FRAME_BITS = 16;

    typedef logic [CH_W-1:0]     chan_t;
    typedef logic [SAMPLE_W-1:0] smp_t;

    localparam chan_t QUAD_LAST = CH_W'(3);

    typedef enum logic [1:0] {
        FMT_QUAD12 = 2'd0,
        FMT_MUX15  = 2'd1,
        FMT_MUX16  = 2'd2,
        FMT_ALT16  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_XFER = 2'd1,
        SQ_GAP  = 2'd2
    } sq_state_e;

    typedef struct packed {
        chan_t ch;
        smp_t  data;
    } result_t;

    function automatic int fmt_width(fmt_e f);
        case (f)
            FMT_QUAD12: return 12;
            FMT_MUX15:  return 15;
            default:    return 16;
        endcase
    endfunction

    function automatic smp_t fmt_align(smp_t raw, fmt_e f);
        smp_t m;
        m = '1;
        m = m >> (SAMPLE_W - fmt_width(f));
        return raw & m;
    endfunction

    function automatic chan_t fmt_last(fmt_e f, chan_t req);
        if (f == FMT_QUAD12 && req > QUAD_LAST) return QUAD_LAST;
        return req;
    endfunction

    function automatic chan_t next_chan(chan_t cur, chan_t last);
        if (cur >= last) return '0;
        return cur + chan_t'(1);
    endfunction

endpackage

// File: rtl/adc_scan_clkdiv.sv
module adc_scan_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim_m1;

    assign lim_m1 = (half_div == '0) ? '0 : half_div - DIV_W'(1);
    assign tick   = run && (cnt_q >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int GAP_HALVES = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    scan_en,
    input  fmt_e    fmt,
    input  chan_t   ch_last,
    input  logic    miso,
    output logic    run,
    output logic    sclk,
    output logic    frame_act,
    output chan_t   csel,
    output logic    wr_valid,
    output result_t wr_res
);
    localparam int EDGES  = 2 * FRAME_BITS;
    localparam int EDGE_W = $clog2(EDGES);
    localparam int GAP_W  = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(EDGES - 1);
    localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(GAP_HALVES - 1);

    sq_state_e           state_q;
    chan_t               ch_q;
    logic [EDGE_W-1:0]   edge_q;
    logic [GAP_W-1:0]    gap_q;
    smp_t                shreg_q;
    logic                sclk_q;
    smp_t                captured;

    assign captured  = {shreg_q[SAMPLE_W-2:0], miso};
    assign run       = (state_q != SQ_IDLE);
    assign frame_act = (state_q == SQ_XFER);
    assign sclk      = sclk_q;

    always_comb begin
        csel = '0;
        if (frame_act) begin
            csel = (fmt == FMT_QUAD12) ? (ch_q & QUAD_LAST) : ch_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            ch_q     <= '0;
            edge_q   <= '0;
            gap_q    <= '0;
            shreg_q  <= '0;
            sclk_q   <= 1'b1;
            wr_valid <= 1'b0;
            wr_res   <= '0;
        end else begin
            wr_valid <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    sclk_q <= 1'b1;
                    if (scan_en) begin
                        state_q <= SQ_XFER;
                        ch_q    <= '0;
                        edge_q  <= '0;
                    end
                end
                SQ_XFER: begin
                    if (tick) begin
                        edge_q <= edge_q + EDGE_W'(1);
                        if (!edge_q[0]) begin
                            sclk_q <= 1'b0;
                        end else begin
                            sclk_q  <= 1'b1;
                            shreg_q <= captured;
                        end
                        if (edge_q == EDGE_LAST) begin
                            state_q     <= SQ_GAP;
                            gap_q       <= '0;
                            wr_valid    <= 1'b1;
                            wr_res.ch   <= ch_q;
                            wr_res.data <= fmt_align(captured, fmt);
                            ch_q        <= next_chan(ch_q, fmt_last(fmt, ch_last));
                        end
                    end
                end
                SQ_GAP: begin
                    if (tick) begin
                        gap_q <= gap_q + GAP_W'(1);
                        if (gap_q == GAP_LAST) begin
                            if (scan_en) begin
                                state_q <= SQ_XFER;
                                edge_q  <= '0;
                            end else begin
                                state_q <= SQ_IDLE;
                            end
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
    import adc_scan_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_valid,
    input  result_t wr_res,
    input  logic    rd_en,
    input  chan_t   rd_addr,
    output logic    rd_valid,
    output smp_t    rd_data,
    output logic    rd_new
);
    smp_t              data_q [NUM_CH];
    logic [NUM_CH-1:0] new_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CH; i++) begin
                data_q[i] <= '0;
            end
            new_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_valid && wr_res.ch == chan_t'(i)) begin
                    data_q[i] <= wr_res.data;
                    new_q[i]  <= 1'b1;
                end else if (rd_en && rd_addr == chan_t'(i)) begin
                    new_q[i]  <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_new   <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= data_q[rd_addr];
                rd_new  <= new_q[rd_addr];
            end
        end
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int GAP_HALVES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_en,
    input  logic [1:0]       fmt_sel,
    input  logic [2:0]       ch_last,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk,
    output logic [2:0]       csel,
    output logic             frame_act,
    input  logic             miso,
    input  logic             rd_en,
    input  logic [2:0]       rd_addr,
    output logic             rd_valid,
    output logic [15:0]      rd_data,
    output logic             rd_new
);
    logic    tick;
    logic    run;
    logic    wr_valid;
    result_t wr_res;
    chan_t   csel_w;

    assign csel = csel_w;

    adc_scan_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half_div (half_div),
        .tick     (tick)
    );

    adc_scan_seq #(.GAP_HALVES(GAP_HALVES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .scan_en   (scan_en),
        .fmt       (fmt_e'(fmt_sel)),
        .ch_last   (ch_last),
        .miso      (miso),
        .run       (run),
        .sclk      (sclk),
        .frame_act (frame_act),
        .csel      (csel_w),
        .wr_valid  (wr_valid),
        .wr_res    (wr_res)
    );

    adc_scan_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_res   (wr_res),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_new   (rd_new)
    );
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk (
    input logic       clk,
    input logic       rst,
    input logic       sclk,
    input logic       frame_act,
    input logic [2:0] csel,
    input logic       rd_en,
    input logic       rd_valid
);
    logic       fa_q;
    logic       sclk_q;
    logic [5:0] rise_cnt;
    logic [3:0] low_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            fa_q     <= 1'b0;
            sclk_q   <= 1'b1;
            rise_cnt <= '0;
            low_len  <= 4'hF;
        end else begin
            fa_q   <= frame_act;
            sclk_q <= sclk;
            if (frame_act && !fa_q) begin
                rise_cnt <= '0;
            end else if (sclk && !sclk_q) begin
                rise_cnt <= rise_cnt + 6'd1;
            end
            if (frame_act) begin
                low_len <= '0;
            end else if (low_len != 4'hF) begin
                low_len <= low_len + 4'd1;
            end
        end
    end

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !frame_act |-> sclk);                                   // R2
    AST_SIXTEEN_CLOCKS: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_act) |=> (rise_cnt == 6'd16));              // R2
    AST_SEL_PARKED: assert property (@(posedge clk) disable iff (rst)
        !frame_act |-> (csel == 3'd0));                         // R5
    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (frame_act && $past(frame_act)) |-> $stable(csel));     // R5
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_act) |-> (low_len >= 4'd4));                // R6
    AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en) |-> rd_valid);                             // R8
    AST_RD_VALID_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> !rd_valid);                           // R8
endmodule

bind adc_scan_ctrl adc_scan_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .frame_act (frame_act),
    .csel      (csel),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid)
);

// File: tb/adc_scan_ctrl_tb_top.sv
module adc_scan_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        scan_en;
    logic [1:0]  fmt_sel;
    logic [2:0]  ch_last;
    logic [7:0]  half_div;
    logic        sclk;
    logic [2:0]  csel;
    logic        frame_act;
    logic        miso;
    logic        rd_en;
    logic [2:0]  rd_addr;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        rd_new;

    always #5 clk = ~clk;

    adc_scan_ctrl dut_i (
        .clk(clk), .rst(rst), .scan_en(scan_en), .fmt_sel(fmt_sel),
        .ch_last(ch_last), .half_div(half_div), .sclk(sclk), .csel(csel),
        .frame_act(frame_act), .miso(miso), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_new(rd_new)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [15:0] exp_res [8];
    bit          exp_new [8];

    logic        fa_p, sclk_p, first_fall;
    logic [2:0]  mon_ch, exp_ch;
    logic [15:0] mon_word;
    int          bit_idx, rises, cyc, gap, frame_no, frames_done;
    int          cur_fmt, cur_last, cur_h;

    assign miso = (bit_idx >= 0 && bit_idx <= 15) ? mon_word[bit_idx] : 1'b0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] gen_word(int n, logic [2:0] c);
        return 16'(16'hC3A5 ^ (n * 16'h1357)) ^ {c, 13'h0A5};
    endfunction

    function automatic logic [15:0] width_mask(int f);
        if (f == 0) return 16'h0FFF;
        if (f == 1) return 16'h7FFF;
        return 16'hFFFF;
    endfunction

    function automatic int eff_last(int f, int l);
        if (f == 0 && l > 3) return 3;
        return l;
    endfunction

    // converter model and per-frame monitor
    always @(negedge clk) begin
        if (rst) begin
            fa_p = 1'b0; sclk_p = 1'b1; bit_idx = -1; rises = 0; cyc = 0;
            gap = 1000; first_fall = 1'b0;
        end else begin
            if (frame_act && !fa_p) begin
                check(csel == exp_ch, "R4", "channel at frame start", csel, exp_ch);
                if (cur_fmt == 0)
                    check(csel[2] == 1'b0, "R5", "quad select bit2", csel[2], 0);
                check(gap >= 4 * cur_h, "R6", "low cycles between frames", gap, 4 * cur_h);
                mon_ch     = csel;
                mon_word   = gen_word(frame_no, csel);
                bit_idx    = 15;
                rises      = 0;
                cyc        = 0;
                first_fall = 1'b1;
                exp_ch     = (int'(exp_ch) >= eff_last(cur_fmt, cur_last)) ? 3'd0 : exp_ch + 3'd1;
            end else begin
                cyc++;
            end
            if (sclk && !sclk_p) begin
                rises++;
                bit_idx--;
            end
            if (!sclk && sclk_p && first_fall) begin
                check(cyc == cur_h, "R2", "cycles to first falling sclk", cyc, cur_h);
                first_fall = 1'b0;
            end
            if (!frame_act && fa_p) begin
                check(rises == 16, "R2", "sclk rises per frame", rises, 16);
                exp_res[mon_ch] = mon_word & width_mask(cur_fmt);
                exp_new[mon_ch] = 1'b1;
                frame_no++;
                frames_done++;
                gap = 1;
            end else if (!frame_act && gap < 100000) begin
                gap++;
            end
            fa_p   = frame_act;
            sclk_p = sclk;
        end
    end

    task automatic read_ch(int ch);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 3'(ch);
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_valid == 1'b1, "R8", "rd_valid after request", rd_valid, 1);
        check(rd_data == exp_res[ch], "R7", $sformatf("data ch%0d (R3 alignment)", ch),
              rd_data, exp_res[ch]);
        check(rd_new == exp_new[ch], "R7", $sformatf("new flag ch%0d", ch), rd_new, exp_new[ch]);
        exp_new[ch] = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; scan_en = 1'b0; rd_en = 1'b0; rd_addr = 3'd0;
        fmt_sel = 2'd2; ch_last = 3'd7; half_div = 8'd2;
        cur_fmt = 2; cur_last = 7; cur_h = 2; exp_ch = 3'd0;
        frame_no = 0; frames_done = 0;
        for (int i = 0; i < 8; i++) begin exp_res[i] = 16'h0; exp_new[i] = 1'b0; end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sclk == 1'b1, "R1", "sclk after reset", sclk, 1);
        check(frame_act == 1'b0, "R1", "frame_act after reset", frame_act, 0);
        check(csel == 3'd0, "R1", "csel after reset", csel, 0);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
        for (int i = 0; i < 8; i++) read_ch(i);
    endtask

    // one scan scenario: run, drop enable mid-frame, verify parking, read back
    task automatic t_scan(int f, int last, int h, int nframes);
        bit ok;
        @(negedge clk);
        fmt_sel = 2'(f); ch_last = 3'(last); half_div = 8'(h);
        cur_fmt = f; cur_last = last; cur_h = h;
        exp_ch = 3'd0; frames_done = 0;
        scan_en = 1'b1;
        while (frames_done < nframes) @(negedge clk);
        while (!frame_act) @(negedge clk);
        repeat (3) @(negedge clk);
        scan_en = 1'b0;
        while (frame_act) @(negedge clk);
        ok = 1'b1;
        repeat (8 * h + 40) begin
            @(negedge clk);
            if (frame_act || !sclk || csel != 3'd0) ok = 1'b0;
        end
        check(ok, "R9", "parked after disable", ok, 1);
        check(frames_done == nframes + 1, "R9", "frame in flight completed",
              frames_done, nframes + 1);
        for (int i = 0; i < 8; i++) read_ch(i);
    endtask

    task automatic t_read_twice(int ch);
        check(exp_new[ch] == 1'b1, "R8", "setup has unread data", exp_new[ch], 1);
        read_ch(ch);
        read_ch(ch);
        check(rd_new == 1'b0, "R8", "flag cleared by read", rd_new, 0);
    endtask

    task automatic t_scan_then_reread();
        @(negedge clk);
        fmt_sel = 2'd2; ch_last = 3'd1; half_div = 8'd1;
        cur_fmt = 2; cur_last = 1; cur_h = 1;
        exp_ch = 3'd0; frames_done = 0;
        scan_en = 1'b1;
        while (frames_done < 2) @(negedge clk);
        scan_en = 1'b0;
        while (frame_act) @(negedge clk);
        repeat (20) @(negedge clk);
        t_read_twice(0);
        t_read_twice(1);
    endtask

    initial begin
        t_reset();
        t_scan(2, 7, 2, 10);   // 16-bit, all eight channels
        t_scan(1, 4, 1, 8);    // 15-bit, wrap after channel 4, fastest clock
        t_scan(0, 7, 3, 6);    // quad 12-bit, channel limit capped at 3
        t_scan(3, 2, 2, 5);    // alternate 16-bit code, three channels
        t_scan_then_reread();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule